// File: doc/BRIEF.md
# Serial Token Row Scanner with Return Monitor

The block steps through the rows of a sensor matrix one at a time using a single travelling bit. A shift chain with one stage per row carries the bit; whichever stage currently holds it raises that row's gate enable and clear enable. The chain has only a serial input, a serial output, a clock and a reset. It keeps no state other than the bit in flight, so rows are always visited in fixed ascending order and none can be skipped.

A controller next to the chain feeds a fresh token into the serial input once per pass, that is, once every `ROWS` clocks, starting in the first cycle after reset. It also keeps a count of completed passes. The serial output leaves the block. It comes back on `ser_back`, which in normal use is wired straight to `ser_out`. A monitor compares that return line with the cycle in which the token ought to arrive. It also checks that exactly one stage is occupied. Any disagreement sets a sticky error flag, so single-event upsets in the chain or on the return path become visible.

Top module: `row_token_scanner`

## Requirements
- R1: While reset is high and in the first cycle after it, every gate and clear enable is 0, `ser_out` is 0, `scan_err` is 0 and `pass_count` is 0.
- R2: Count cycles from c = 0, the first cycle with reset low. A token is injected in cycle 0 and again in every cycle c that is a multiple of `ROWS`. Each injected token shows up on row 0 in cycle c + 1.
- R3: From cycle 1 onward exactly one row is enabled at a time. Row r is enabled in cycle c exactly when (c - 1) mod `ROWS` equals r, so rows advance by one per clock in ascending order.
- R4: `clear_en` equals `gate_en` in every cycle; bit r of each belongs to row r.
- R5: `ser_out` is 1 exactly in cycles c = k * `ROWS` for k >= 1, which is `ROWS` clocks after the matching injection, and is 0 in all other cycles.
- R6: `pass_count` equals floor(c / `ROWS`) modulo 2^`CNT_W` and changes at the clock edge that begins cycle k * `ROWS`.
- R7: A 1 on `ser_back` in a cycle where no return is expected sets `scan_err` from the next cycle on. This covers a return that comes early and an extra one bit.
- R8: A 0 on `ser_back` in a cycle c = k * `ROWS` (k >= 1) is a missing return and sets `scan_err` from the next cycle on.
- R9: `scan_err` stays at 1 until reset, and only reset clears it. Scanning, injection and pass counting go on unchanged while it is set.
- R10: With `ser_back` tied to `ser_out` and no upset, `scan_err` stays at 0 in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock, one row per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ser_back | input | 1 | Serial output as received back at the monitor |
| gate_en | output | ROWS | Per-row gate enable, one-hot while scanning |
| clear_en | output | ROWS | Per-row clear enable, same timing as gate_en |
| ser_out | output | 1 | Last chain stage, the returning token |
| scan_err | output | 1 | Sticky error: wrong, missing or extra return, or bad occupancy |
| pass_count | output | CNT_W | Number of completed passes, wrapping |

## Verification
A wrong internal state shows up at the ports very quickly. A dropped or doubled token, or a counter that is off by one, changes the one-hot `gate_en` pattern within a cycle. The same fault moves the `ser_out` pulse away from its multiple-of-`ROWS` cycle within one pass. A controller whose expectation window is shifted raises `scan_err` at the first return, one cycle after cycle `ROWS`. The bench sweeps several full passes of a small chain cycle by cycle against arithmetic expectations, and corrupts `ser_back` at early, extra and missing points to show that the flag is raised one cycle later and then held.

// File: rtl/scan_pkg.sv
package scan_pkg;
  localparam int unsigned DEF_ROWS  = 128;
  localparam int unsigned DEF_CNT_W = 16;

  // Reason the monitor latched an error; kept inside the monitor only.
  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_RETURN = 2'd1,
    FLT_OCCUPY = 2'd2
  } fault_e;
endpackage

// File: rtl/scan_token_chain.sv
module scan_token_chain #(
  parameter int unsigned ROWS = scan_pkg::DEF_ROWS
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ser_in,
  output logic            ser_out,
  output logic [ROWS-1:0] row_hot,
  output logic            single_hot
);
  logic [ROWS-1:0] stage_q;

  // One flop per row; each takes its neighbour's bit, the first takes ser_in.
  genvar gi;
  generate
    for (gi = 0; gi < ROWS; gi++) begin : g_stage
      logic d_in;
      if (gi == 0) begin : g_head
        assign d_in = ser_in;
      end else begin : g_body
        assign d_in = stage_q[gi-1];
      end
      always_ff @(posedge clk) begin
        if (rst) stage_q[gi] <= 1'b0;
        else     stage_q[gi] <= d_in;
      end
    end
  endgenerate

  assign ser_out    = stage_q[ROWS-1];
  assign row_hot    = stage_q;
  assign single_hot = ($countones(stage_q) == 1);

  // R3: never more than one row driven
  a_r3_chain_onehot0: assert property (@(posedge clk) disable iff (rst)
    $onehot0(stage_q));
endmodule

// File: rtl/scan_inject_ctrl.sv
module scan_inject_ctrl #(
  parameter int unsigned ROWS  = scan_pkg::DEF_ROWS,
  parameter int unsigned CNT_W = scan_pkg::DEF_CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  output logic             ser_in,
  output logic             expect_ret,
  output logic [CNT_W-1:0] pass_count
);
  localparam int unsigned PH_W = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(ROWS - 1);

  logic [PH_W-1:0]  phase_q;
  logic             armed_q;
  logic [CNT_W-1:0] cnt_q;
  logic             wrap;

  assign wrap = (phase_q == PH_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      phase_q <= wrap ? '0 : phase_q + 1'b1;
      if (wrap) begin
        armed_q <= 1'b1;
        cnt_q   <= cnt_q + 1'b1;
      end
    end
  end

  assign ser_in     = (phase_q == '0);
  assign expect_ret = armed_q && (phase_q == '0);
  assign pass_count = cnt_q;

  // R2: one injection per pass, never on consecutive clocks
  a_r2_single_inject: assert property (@(posedge clk) disable iff (rst)
    ser_in |=> !ser_in);
  // R6: the pass count moves only when a return becomes due
  a_r6_count_step: assert property (@(posedge clk) disable iff (rst)
    !expect_ret |=> (expect_ret || $stable(cnt_q)));
endmodule

// File: rtl/scan_return_monitor.sv
module scan_return_monitor (
  input  logic clk,
  input  logic rst,
  input  logic ser_back,
  input  logic expect_ret,
  input  logic single_hot,
  output logic scan_err
);
  import scan_pkg::*;

  logic   live_q;
  logic   err_q;
  fault_e cause_q;
  logic   ret_bad;
  logic   occ_bad;

  assign ret_bad = (ser_back != expect_ret);
  assign occ_bad = live_q && !single_hot;

  always_ff @(posedge clk) begin
    if (rst) begin
      live_q  <= 1'b0;
      err_q   <= 1'b0;
      cause_q <= FLT_NONE;
    end else begin
      live_q <= 1'b1;
      if (!err_q && (ret_bad || occ_bad)) begin
        err_q   <= 1'b1;
        cause_q <= ret_bad ? FLT_RETURN : FLT_OCCUPY;
      end
    end
  end

  assign scan_err = err_q;

  // R9: sticky until reset
  a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
    scan_err |=> scan_err);
  // R8: a missing return raises the flag
  a_r8_missing: assert property (@(posedge clk) disable iff (rst)
    (expect_ret && !ser_back) |=> scan_err);
  // R7: an unexpected one raises the flag
  a_r7_unexpected: assert property (@(posedge clk) disable iff (rst)
    (!expect_ret && ser_back) |=> scan_err);
  // R9: a cause is always recorded with the flag
  a_r9_cause: assert property (@(posedge clk) disable iff (rst)
    scan_err |-> (cause_q != FLT_NONE));
endmodule

// File: rtl/row_token_scanner.sv
module row_token_scanner #(
  parameter int unsigned ROWS  = scan_pkg::DEF_ROWS,
  parameter int unsigned CNT_W = scan_pkg::DEF_CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ser_back,
  output logic [ROWS-1:0]  gate_en,
  output logic [ROWS-1:0]  clear_en,
  output logic             ser_out,
  output logic             scan_err,
  output logic [CNT_W-1:0] pass_count
);
  logic            ser_in;
  logic            expect_ret;
  logic            single_hot;
  logic [ROWS-1:0] row_hot;

  scan_inject_ctrl #(.ROWS(ROWS), .CNT_W(CNT_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .ser_in     (ser_in),
    .expect_ret (expect_ret),
    .pass_count (pass_count)
  );

  scan_token_chain #(.ROWS(ROWS)) u_chain (
    .clk        (clk),
    .rst        (rst),
    .ser_in     (ser_in),
    .ser_out    (ser_out),
    .row_hot    (row_hot),
    .single_hot (single_hot)
  );

  scan_return_monitor u_mon (
    .clk        (clk),
    .rst        (rst),
    .ser_back   (ser_back),
    .expect_ret (expect_ret),
    .single_hot (single_hot),
    .scan_err   (scan_err)
  );

  assign gate_en  = row_hot;
  assign clear_en = row_hot;

  // R1: reset leaves everything quiet
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (gate_en == '0 && !ser_out && !scan_err && pass_count == '0));
  // R5: the serial output only rises when a return is due
  a_r5_ret_window: assert property (@(posedge clk) disable iff (rst)
    ser_out |-> expect_ret);
  // R3: the last row hands over to row 0 on the following clock
  a_r3_wrap: assert property (@(posedge clk) disable iff (rst)
    gate_en[ROWS-1] |=> gate_en[0]);
endmodule

// File: tb/sim_row_token_scanner.sv
`timescale 1ns/100ps
module sim_row_token_scanner;
  localparam int N = 8;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         ovr_en = 1'b0;
  logic         ovr_val = 1'b0;
  logic         ser_back;
  logic [N-1:0] gate_en, clear_en;
  logic         ser_out, scan_err;
  logic [W-1:0] pass_count;

  int  cyc = 0;
  int  tests = 0;
  int  fails = 0;
  bit  done = 0;
  logic err_exp = 1'b0;

  always #2.5 clk = ~clk;

  assign ser_back = ovr_en ? ovr_val : ser_out;

  row_token_scanner #(.ROWS(N), .CNT_W(W)) u0 (
    .clk(clk), .rst(rst), .ser_back(ser_back),
    .gate_en(gate_en), .clear_en(clear_en), .ser_out(ser_out),
    .scan_err(scan_err), .pass_count(pass_count)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s cycle %0d: actual %0h expected %0h", req, cyc, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    cyc++;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    ovr_en = 1'b0;
    err_exp = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 gate in reset", gate_en, '0);
    chk("R1 err in reset", scan_err, 0);
    chk("R1 count in reset", pass_count, 0);
    rst = 1'b0;
    cyc = 0;
  endtask

  task automatic check_cycle();
    logic [N-1:0] g;
    g = (cyc >= 1) ? (N'(1) << ((cyc - 1) % N)) : '0;
    chk("R2 R3 gate_en", gate_en, g);
    chk("R4 clear_en", clear_en, gate_en);
    chk("R5 ser_out", ser_out, (cyc >= N && cyc % N == 0));
    chk("R6 pass_count", pass_count, (cyc / N) % (1 << W));
    chk("R9 R10 scan_err", scan_err, err_exp);
  endtask

  task automatic run_to(input int target);
    while (cyc < target) begin
      check_cycle();
      step();
    end
  endtask

  task automatic poke(input logic v);
    ovr_en = 1'b1;
    ovr_val = v;
    step();
    ovr_en = 1'b0;
    err_exp = 1'b1;
    chk("R7 R8 flag raised", scan_err, 1);
  endtask

  initial begin
    // R1, R2-R6, R10: clean sweep over more passes than the count width holds
    do_reset();
    chk("R1 first cycle gate", gate_en, '0);
    chk("R1 first cycle ser_out", ser_out, 0);
    run_to(N * 18 + 3);
    check_cycle();

    // R7: extra one mid-pass, then R9 sticky while scanning continues
    do_reset();
    run_to(3);
    poke(1'b1);
    run_to(3 * N + 2);

    // R7: return one cycle early
    do_reset();
    run_to(N - 1);
    poke(1'b1);
    run_to(2 * N + 1);

    // R8: first return correct, second one missing
    do_reset();
    run_to(2 * N);
    poke(1'b0);
    run_to(4 * N);

    // R7: one bit in cycle 0, before any return can be due
    do_reset();
    poke(1'b1);
    run_to(N + 2);

    // R9: only reset clears the flag
    do_reset();
    run_to(N + 1);
    check_cycle();

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule